// File: doc/BRIEF.md
# Correlation-Table Miss Prefetcher

This block watches the stream of cache-miss block addresses and learns which addresses tend to come next after each one. It keeps a direct-mapped table keyed by block address. Each entry holds a small set of successor candidates, and each candidate has a saturating confidence counter. Every accepted miss does two things, in this order. First, it is recorded as a successor of the miss accepted before it. Second, it is looked up in the table. When the lookup finds a live entry, the block issues that entry's candidates as prefetch requests, highest confidence first, one per accepted handshake.

The block suits irregular access patterns such as pointer chains, where stride detection fails. It cannot help on first-touch misses, because an address with no recorded history yields no prefetch. The miss input offers a ready signal. A new miss is taken only after the previous miss has been recorded, looked up, and its whole issue list drained.

Top module: `mkv_prefetch`

## Requirements
- R1: After reset, `miss_ready` is 1, `pf_valid` is 0, and the table holds no entries, so no miss produces a prefetch until history has been recorded.
- R2: A miss is taken only on a cycle where both `miss_valid` and `miss_ready` are 1. `miss_ready` stays 0 from the cycle after acceptance until the last prefetch of that lookup has handshaken. While `miss_ready` is 0, `miss_valid` and `miss_addr` have no effect.
- R3: When miss S is accepted right after miss K, S is stored as a candidate in K's entry. A newly stored candidate starts at confidence 1.
- R4: When miss S follows K again and S is already a candidate of K, that candidate's confidence increases by one. The confidence saturates at 3.
- R5: The table has 64 entries. The index is bits [5:0] of the block address and the tag is bits [31:6]. A lookup whose entry is empty, or whose tag differs, issues nothing.
- R6: If recording a successor for K finds the entry at K's index holding another tag, the entry is reallocated to K. All old candidates are discarded, and only the new successor remains.
- R7: An entry holds up to 4 candidates. A new successor fills the lowest-numbered empty slot. When all slots are full, it replaces the candidate with the lowest confidence (lowest slot on a tie) and starts at confidence 1.
- R8: Candidates are issued in descending confidence order. Candidates of equal confidence are issued in ascending slot order.
- R9: A candidate equal to the triggering miss address is never issued. A candidate with confidence 0 is never issued.
- R10: While `pf_valid` is 1 and `pf_ready` is 0, `pf_valid` stays 1 and `pf_addr` does not change.
- R11: A single lookup issues at most 4 prefetches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | A miss block address is offered |
| miss_addr | input | 32 | Miss block address |
| miss_ready | output | 1 | Block is idle and takes a miss this cycle |
| pf_valid | output | 1 | A prefetch request is offered |
| pf_ready | input | 1 | Consumer takes the prefetch request |
| pf_addr | output | 32 | Prefetch block address |

## Verification
The assertions assume that the consumer of prefetch requests may hold `pf_ready` low for any number of cycles. They also assume that `miss_valid` may stay high while the block is busy. The stimulus uses both freedoms. It holds `pf_ready` low about a third of the time, and it keeps `miss_valid` asserted with a random decoy address for the whole busy window. Miss addresses come from a small pool that shares only a few table indexes. This forces tag conflicts, reallocation, full-entry replacement and counter saturation. It also produces triggers that are their own successors.

// File: rtl/mkv_pkg.sv
package mkv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for a miss
    ST_UPD,    // key entry read back, write updated entry
    ST_LRD,    // present the lookup index
    ST_LOOK,   // lookup data back, build ranked issue list
    ST_ISSUE   // hand candidates out one per handshake
  } mkv_state_e;
endpackage

// File: rtl/mkv_table.sv
module mkv_table #(
  parameter int IDX_W  = 6,
  parameter int DATA_W = 162
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rd_vld,
  output logic [DATA_W-1:0] rd_data
);
  localparam int SETS = 1 << IDX_W;

  // payload kept reset-free so it maps onto block RAM; valid bits in flops
  logic [DATA_W-1:0] mem_r [SETS];
  logic [SETS-1:0]   vld_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem_r[wr_idx] <= wr_data;
    rd_data <= mem_r[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= '0;
      rd_vld <= 1'b0;
    end else begin
      if (wr_en) vld_q[wr_idx] <= 1'b1;
      rd_vld <= vld_q[rd_idx];
    end
  end
endmodule

// File: rtl/mkv_update.sv
module mkv_update #(
  parameter int ADDR_W = 32,
  parameter int CANDS  = 4,
  parameter int CONF_W = 2
) (
  input  logic                           hit,
  input  logic [CANDS-1:0][ADDR_W-1:0]   in_addrs,
  input  logic [CANDS-1:0][CONF_W-1:0]   in_confs,
  input  logic [ADDR_W-1:0]              succ,
  output logic [CANDS-1:0][ADDR_W-1:0]   out_addrs,
  output logic [CANDS-1:0][CONF_W-1:0]   out_confs
);
  localparam logic [CONF_W-1:0] CONF_MAX = '1;
  localparam logic [CONF_W-1:0] CONF_ONE = CONF_W'(1);

  always_comb begin
    int  hit_slot, free_slot, low_slot;
    logic found, has_free;
    out_addrs = hit ? in_addrs : '0;
    out_confs = hit ? in_confs : '0;
    found = 1'b0; has_free = 1'b0;
    hit_slot = 0; free_slot = 0; low_slot = 0;
    for (int i = 0; i < CANDS; i++) begin
      if (!found && out_confs[i] != '0 && out_addrs[i] == succ) begin
        found = 1'b1; hit_slot = i;
      end
      if (!has_free && out_confs[i] == '0) begin
        has_free = 1'b1; free_slot = i;
      end
      if (out_confs[i] < out_confs[low_slot]) low_slot = i;
    end
    if (found) begin
      if (out_confs[hit_slot] != CONF_MAX)
        out_confs[hit_slot] = out_confs[hit_slot] + CONF_ONE;
    end else if (has_free) begin
      out_addrs[free_slot] = succ;
      out_confs[free_slot] = CONF_ONE;
    end else begin
      out_addrs[low_slot] = succ;
      out_confs[low_slot] = CONF_ONE;
    end
  end
endmodule

// File: rtl/mkv_rank.sv
module mkv_rank #(
  parameter int ADDR_W = 32,
  parameter int CANDS  = 4,
  parameter int CONF_W = 2,
  parameter int CNT_W  = 3
) (
  input  logic                          hit,
  input  logic [CANDS-1:0][ADDR_W-1:0]  addrs,
  input  logic [CANDS-1:0][CONF_W-1:0]  confs,
  input  logic [ADDR_W-1:0]             trig,
  output logic [CANDS-1:0][ADDR_W-1:0]  list,
  output logic [CNT_W-1:0]              cnt
);
  localparam int CONF_TOP = (1 << CONF_W) - 1;

  always_comb begin
    int n;
    list = '0;
    n = 0;
    if (hit) begin
      for (int c = CONF_TOP; c >= 1; c--) begin
        for (int i = 0; i < CANDS; i++) begin
          if (confs[i] == CONF_W'(c) && addrs[i] != trig && n < CANDS) begin
            list[n] = addrs[i];
            n = n + 1;
          end
        end
      end
    end
    cnt = CNT_W'(n);
  end
endmodule

// File: rtl/mkv_prefetch.sv
module mkv_prefetch #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6,
  parameter int CANDS  = 4,
  parameter int CONF_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_addr,
  output logic              miss_ready,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [ADDR_W-1:0] pf_addr
);
  import mkv_pkg::*;

  localparam int TAG_W  = ADDR_W - IDX_W;
  localparam int SLOT_W = ADDR_W + CONF_W;
  localparam int ENT_W  = TAG_W + CANDS * SLOT_W;
  localparam int CNT_W  = $clog2(CANDS + 1);

  mkv_state_e state_q;
  logic [ADDR_W-1:0] cur_q, prev_q;
  logic              prev_vld_q;
  logic [CANDS-1:0][ADDR_W-1:0] list_q;
  logic [CNT_W-1:0]  cnt_q;

  logic [IDX_W-1:0]  rd_idx;
  logic              rd_vld;
  logic [ENT_W-1:0]  rd_data, wr_data;
  logic [TAG_W-1:0]  rd_tag;
  logic [CANDS-1:0][ADDR_W-1:0] rd_addrs, new_addrs, rank_list;
  logic [CANDS-1:0][CONF_W-1:0] rd_confs, new_confs;
  logic [CNT_W-1:0]  rank_cnt;
  logic              upd_hit, lk_hit;

  assign rd_idx   = (state_q == ST_IDLE) ? prev_q[IDX_W-1:0] : cur_q[IDX_W-1:0];
  assign rd_tag   = rd_data[ENT_W-1 -: TAG_W];
  assign rd_addrs = rd_data[CANDS*SLOT_W-1 -: CANDS*ADDR_W];
  assign rd_confs = rd_data[CANDS*CONF_W-1:0];
  assign upd_hit  = rd_vld && (rd_tag == prev_q[ADDR_W-1:IDX_W]);
  assign lk_hit   = rd_vld && (rd_tag == cur_q[ADDR_W-1:IDX_W]);
  assign wr_data  = {prev_q[ADDR_W-1:IDX_W], new_addrs, new_confs};

  mkv_table #(.IDX_W(IDX_W), .DATA_W(ENT_W)) table_i (
    .clk(clk), .rst(rst), .rd_idx(rd_idx),
    .wr_en(state_q == ST_UPD), .wr_idx(prev_q[IDX_W-1:0]), .wr_data(wr_data),
    .rd_vld(rd_vld), .rd_data(rd_data)
  );

  mkv_update #(.ADDR_W(ADDR_W), .CANDS(CANDS), .CONF_W(CONF_W)) update_i (
    .hit(upd_hit), .in_addrs(rd_addrs), .in_confs(rd_confs), .succ(cur_q),
    .out_addrs(new_addrs), .out_confs(new_confs)
  );

  mkv_rank #(.ADDR_W(ADDR_W), .CANDS(CANDS), .CONF_W(CONF_W), .CNT_W(CNT_W)) rank_i (
    .hit(lk_hit), .addrs(rd_addrs), .confs(rd_confs), .trig(cur_q),
    .list(rank_list), .cnt(rank_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      cur_q      <= '0;
      prev_q     <= '0;
      prev_vld_q <= 1'b0;
      list_q     <= '0;
      cnt_q      <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (miss_valid) begin
          cur_q   <= miss_addr;
          state_q <= prev_vld_q ? ST_UPD : ST_LRD;
        end
        ST_UPD: state_q <= ST_LRD;
        ST_LRD: state_q <= ST_LOOK;
        ST_LOOK: begin
          list_q     <= rank_list;
          cnt_q      <= rank_cnt;
          prev_q     <= cur_q;
          prev_vld_q <= 1'b1;
          state_q    <= (rank_cnt != '0) ? ST_ISSUE : ST_IDLE;
        end
        ST_ISSUE: if (pf_ready) begin
          for (int i = 0; i < CANDS - 1; i++) list_q[i] <= list_q[i+1];
          list_q[CANDS-1] <= '0;
          cnt_q <= cnt_q - CNT_W'(1);
          if (cnt_q == CNT_W'(1)) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign miss_ready = (state_q == ST_IDLE);
  assign pf_valid   = (state_q == ST_ISSUE);
  assign pf_addr    = list_q[0];
endmodule

// File: rtl/mkv_prefetch_chk.sv
module mkv_prefetch_chk #(
  parameter int ADDR_W = 32,
  parameter int CANDS  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              miss_ready,
  input logic              pf_valid,
  input logic              pf_ready,
  input logic [ADDR_W-1:0] pf_addr,
  input logic [ADDR_W-1:0] trig
);
  logic [7:0] issued_q;

  always_ff @(posedge clk) begin
    if (rst || miss_ready) issued_q <= '0;
    else if (pf_valid && pf_ready) issued_q <= issued_q + 8'd1;
  end

  // R10: an offered request is held unchanged until taken
  a_r10_hold_request: assert property (@(posedge clk) disable iff (rst)
    pf_valid && !pf_ready |=> pf_valid && $stable(pf_addr));

  // R2: no miss is taken while requests are still being issued
  a_r2_busy_while_issuing: assert property (@(posedge clk) disable iff (rst)
    pf_valid |-> !miss_ready);

  // R9: the trigger address is never requested
  a_r9_no_self_prefetch: assert property (@(posedge clk) disable iff (rst)
    pf_valid |-> pf_addr != trig);

  // R11: at most CANDS handshakes per lookup
  a_r11_issue_limit: assert property (@(posedge clk) disable iff (rst)
    issued_q <= 8'(CANDS));

  // R1: nothing offered straight after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !pf_valid && miss_ready);
endmodule

bind mkv_prefetch mkv_prefetch_chk #(.ADDR_W(ADDR_W), .CANDS(CANDS)) chk_i (
  .clk(clk), .rst(rst), .miss_ready(miss_ready), .pf_valid(pf_valid),
  .pf_ready(pf_ready), .pf_addr(pf_addr), .trig(cur_q)
);

// File: tb/mkv_prefetch_tb.sv
`timescale 1ns/1ps
module mkv_prefetch_tb_top;
  localparam int AW = 32;
  localparam int NC = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic miss_valid = 1'b0;
  logic [AW-1:0] miss_addr = '0;
  logic miss_ready, pf_valid, pf_ready = 1'b0;
  logic [AW-1:0] pf_addr;

  int vectors = 0;
  int errors  = 0;

  always #2.5 clk = ~clk;

  mkv_prefetch dut_i (
    .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_addr(miss_addr),
    .miss_ready(miss_ready), .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr)
  );

  // reference table built from the requirements
  logic          m_vld  [64];
  logic [25:0]   m_tag  [64];
  logic [AW-1:0] m_addr [64][NC];
  int            m_conf [64][NC];
  logic [AW-1:0] m_prev;
  logic          m_prev_vld;
  logic [AW-1:0] exp_list [NC];
  int            exp_n;

  function automatic void model_record(logic [AW-1:0] k, logic [AW-1:0] s);
    int i, hit, fr, lo;
    i = int'(k[5:0]);
    if (!m_vld[i] || m_tag[i] != k[31:6]) begin   // R6 reallocation
      m_vld[i] = 1'b1; m_tag[i] = k[31:6];
      for (int j = 0; j < NC; j++) begin m_conf[i][j] = 0; m_addr[i][j] = '0; end
    end
    hit = -1; fr = -1; lo = 0;
    for (int j = 0; j < NC; j++) begin
      if (hit < 0 && m_conf[i][j] != 0 && m_addr[i][j] == s) hit = j;
      if (fr < 0 && m_conf[i][j] == 0) fr = j;
      if (m_conf[i][j] < m_conf[i][lo]) lo = j;
    end
    if (hit >= 0) begin
      if (m_conf[i][hit] < 3) m_conf[i][hit]++;               // R4
    end else if (fr >= 0) begin
      m_addr[i][fr] = s; m_conf[i][fr] = 1;                     // R3
    end else begin
      m_addr[i][lo] = s; m_conf[i][lo] = 1;                     // R7
    end
  endfunction

  function automatic void model_lookup(logic [AW-1:0] a);
    int i;
    i = int'(a[5:0]);
    exp_n = 0;
    if (m_vld[i] && m_tag[i] == a[31:6])
      for (int c = 3; c >= 1; c--)                              // R8
        for (int j = 0; j < NC; j++)
          if (m_conf[i][j] == c && m_addr[i][j] != a) begin     // R9
            exp_list[exp_n] = m_addr[i][j];
            exp_n++;
          end
  endfunction

  task automatic check(input bit ok, input string req, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_miss(input logic [AW-1:0] a, input string req);
    logic [AW-1:0] obs [8];
    logic [AW-1:0] held_addr;
    int n;
    bit held, done, r;
    if (m_prev_vld) model_record(m_prev, a);
    model_lookup(a);
    m_prev = a; m_prev_vld = 1'b1;

    @(negedge clk);
    while (!miss_ready) @(negedge clk);
    miss_valid = 1'b1; miss_addr = a;
    @(negedge clk);
    check(!miss_ready, "R2", AW'(miss_ready), '0);
    miss_addr = $urandom;                       // decoy while busy (R2)
    n = 0; held = 1'b0; done = 1'b0; held_addr = '0;
    for (int cyc = 0; cyc < 200; cyc++) begin
      if (miss_ready) begin done = 1'b1; break; end
      if (held) check(pf_valid && pf_addr == held_addr, "R10", pf_addr, held_addr);
      r = ($urandom % 100) < 65;
      pf_ready = r;
      if (pf_valid && r) begin
        if (n < 8) obs[n] = pf_addr;
        n++; held = 1'b0;
      end else if (pf_valid) begin
        held = 1'b1; held_addr = pf_addr;
      end
      @(negedge clk);
    end
    miss_valid = 1'b0; pf_ready = 1'b0;
    check(done, "watchdog", '0, AW'(1));
    check(n <= NC, "R11", AW'(n), AW'(NC));
    check(n == exp_n, req, AW'(n), AW'(exp_n));
    for (int k = 0; k < exp_n && k < n && k < 8; k++)
      check(obs[k] == exp_list[k], req, obs[k], exp_list[k]);
  endtask

  localparam logic [AW-1:0] A = 32'h0000_1001, B = 32'h0000_2002, C = 32'h0000_3003;
  localparam logic [AW-1:0] D = 32'h0000_4004, E = 32'h0000_5005, F = 32'h0000_6006;
  localparam logic [AW-1:0] X = 32'h0000_7001;  // same index as A, other tag

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) begin
      m_vld[i] = 1'b0; m_tag[i] = '0;
      for (int j = 0; j < NC; j++) begin m_conf[i][j] = 0; m_addr[i][j] = '0; end
    end
    m_prev = '0; m_prev_vld = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(miss_ready && !pf_valid, "R1", {30'd0, miss_ready, pf_valid}, 32'd2);

    run_miss(A, "R1");
    run_miss(B, "R5");
    run_miss(A, "R3");
    repeat (4) begin run_miss(B, "R4"); run_miss(A, "R4"); end
    run_miss(C, "R7"); run_miss(A, "R7");
    run_miss(D, "R7"); run_miss(A, "R7");
    run_miss(E, "R7"); run_miss(A, "R8");
    run_miss(F, "R7"); run_miss(A, "R8");
    run_miss(A, "R9"); run_miss(A, "R9"); run_miss(A, "R9");
    run_miss(X, "R6"); run_miss(B, "R6"); run_miss(A, "R6");

    for (int t = 0; t < 600; t++) begin
      logic [AW-1:0] ra;
      ra = {24'h0, 2'($urandom % 4), 6'h0} + AW'($urandom % 4);
      ra[31:12] = 20'($urandom % 2);
      run_miss(ra, "R8");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule